// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Store Access Controller

This block gives a small processor bus byte access to a 512-entry nonvolatile data store. In this design the store is an on-chip array. Software works through four byte-wide registers selected by a two-bit register select:

- a control/status register;
- a data register;
- a low address byte;
- a high address byte that holds only address bit 8.

A read operation copies the addressed byte into the data register. A write operation takes the byte to store from the data register.

Every accepted operation raises a processor stall output for a fixed number of cycles. A read stalls for four cycles and a write for two. After its stall ends, a write runs on in the background for a parameterised number of cycles. During that time a busy flag is set, and software polls it before starting the next access.

To guard against stray stores, a write is taken only when a separate arming write has opened a short acceptance window first. The window lasts four cycles and closes by itself.

Top module: `nvb_ctrl`

## Requirements
- R1: The store holds 512 bytes at addresses 0 to 511. The 9-bit address is formed from the low address byte and bit 0 of the high address byte. Each location keeps its own value independently of the others.
- R2: The register select chooses a register by value:
  - 0 selects control/status;
  - 1 selects data;
  - 2 selects the low address byte;
  - 3 selects the high address byte.

  Reading the high address byte returns address bit 8 in bit 0 and zero in bits 7..1. Bits 7..1 written to it are discarded.
- R3: A write operation stores the data register at the current address. A read operation loads the data register with the byte at the current address.
- R4: A bus write to control with bit 0 (read strobe) set and bit 1 clear, while the block is neither busy nor stalling, is accepted as a read. `cpu_stall` is then high for exactly 4 cycles, starting with the cycle after the accepting edge.
- R5: An accepted write holds `cpu_stall` high for exactly 2 cycles, starting with the cycle after the accepting edge.
- R6: Control bit 3 (busy) is 1 for exactly WR_CYCLES cycles after an accepted write. The store takes the new byte when busy falls.
- R7: After reset the data register reads 0x00, the control register reads 0x00 and `cpu_stall` is low.
- R8: A control write with bit 1 (write strobe) set is ignored in two cases: when no window is open, and when bit 2 (arm) is set in the same write. An ignored strobe causes no stall, no busy and no change to the store.
- R9: A control write with bit 2 set opens a window of 4 cycles. During the window control bit 2 reads 1, and a write strobe is accepted at any of the 4 following edges. Bit 2 clears when the window expires or when a write is accepted.
- R10: Read and write strobes that arrive while busy or while stalling are ignored. They start no stall and leave the data register unchanged.
- R11: Control bits 1 and 0 always read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe for this cycle |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| cpu_stall | output | 1 | Processor hold request |

## Verification
Two events can fall on the same clock edge: the arming window closing, and a write strobe arriving. The bench provokes this by placing the strobe exactly on the fourth edge after arming, which must be accepted, and on the fifth edge, which must be rejected. It judges the outcome by the stall and busy seen at the ports and by reading the location back afterwards.

A second coincidence is a read strobe issued while a background write is still busy. The bench checks that this strobe produces no stall and leaves the data register unchanged. A behavioural model compares read data and stall on every cycle.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_DATA    = 2'd1,
        SEL_ADDR_LO = 2'd2,
        SEL_ADDR_HI = 2'd3
    } reg_sel_e;

    localparam int CTL_RD   = 0;
    localparam int CTL_WR   = 1;
    localparam int CTL_ARM  = 2;
    localparam int CTL_BUSY = 3;

    typedef struct packed {
        logic rd;
        logic wr;
        logic arm;
    } ctl_req_t;

    typedef struct packed {
        logic rd_go;
        logic wr_go;
        logic wr_done;
    } op_evt_t;

    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvb_regs.sv
module nvb_regs
    import nvb_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ld_data,
    input  logic [DATA_W-1:0] ld_value,
    input  logic              arm,
    input  logic              busy,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output ctl_req_t          req,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int HI_W = ADDR_W - DATA_W;

    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_sel);

    // Address register deliberately has no reset value
    always_ff @(posedge clk) begin
        if (bus_we && sel == SEL_ADDR_LO) addr_q[DATA_W-1:0] <= bus_wdata;
        if (bus_we && sel == SEL_ADDR_HI) addr_q[ADDR_W-1:DATA_W] <= bus_wdata[HI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)                              data_q <= '0;
        else if (ld_data)                     data_q <= ld_value;
        else if (bus_we && sel == SEL_DATA)   data_q <= bus_wdata;
    end

    always_comb begin
        req     = '0;
        req.rd  = bus_we && sel == SEL_CTRL && bus_wdata[CTL_RD];
        req.wr  = bus_we && sel == SEL_CTRL && bus_wdata[CTL_WR];
        req.arm = bus_we && sel == SEL_CTRL && bus_wdata[CTL_ARM];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CTRL: begin
                bus_rdata[CTL_ARM]  = arm;
                bus_rdata[CTL_BUSY] = busy;
            end
            SEL_DATA:    bus_rdata = data_q;
            SEL_ADDR_LO: bus_rdata = addr_q[DATA_W-1:0];
            SEL_ADDR_HI: bus_rdata[HI_W-1:0] = addr_q[ADDR_W-1:DATA_W];
        endcase
    end

endmodule

// File: rtl/nvb_seq.sv
module nvb_seq
    import nvb_pkg::*;
#(
    parameter int RD_STALL  = 4,
    parameter int WR_STALL  = 2,
    parameter int ARM_WIN   = 4,
    parameter int WR_CYCLES = 40
) (
    input  logic     clk,
    input  logic     rst,
    input  ctl_req_t req,
    output op_evt_t  evt,
    output logic     stall,
    output logic     busy,
    output logic     arm
);
    localparam int SW = cnt_width(max2(RD_STALL, WR_STALL));
    localparam int AW = cnt_width(ARM_WIN);
    localparam int BW = cnt_width(WR_CYCLES);

    logic [SW-1:0] stall_cnt;
    logic [AW-1:0] arm_cnt;
    logic [BW-1:0] busy_cnt;
    logic          idle;

    assign stall = stall_cnt != '0;
    assign busy  = busy_cnt  != '0;
    assign arm   = arm_cnt   != '0;
    assign idle  = !stall && !busy;

    always_comb begin
        evt         = '0;
        evt.wr_go   = req.wr && !req.arm && arm && idle;
        evt.rd_go   = req.rd && !req.wr && idle;
        evt.wr_done = busy_cnt == BW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)              arm_cnt <= '0;
        else if (evt.wr_go)   arm_cnt <= '0;
        else if (req.arm)     arm_cnt <= AW'(ARM_WIN);
        else if (arm)         arm_cnt <= arm_cnt - AW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)              stall_cnt <= '0;
        else if (evt.rd_go)   stall_cnt <= SW'(RD_STALL);
        else if (evt.wr_go)   stall_cnt <= SW'(WR_STALL);
        else if (stall)       stall_cnt <= stall_cnt - SW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)              busy_cnt <= '0;
        else if (evt.wr_go)   busy_cnt <= BW'(WR_CYCLES);
        else if (busy)        busy_cnt <= busy_cnt - BW'(1);
    end

endmodule

// File: rtl/nvb_array.sv
module nvb_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
    import nvb_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int DATA_W    = 8,
    parameter int RD_STALL  = 4,
    parameter int WR_STALL  = 2,
    parameter int ARM_WIN   = 4,
    parameter int WR_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_stall
);
    ctl_req_t          req;
    op_evt_t           evt;
    logic              busy;
    logic              arm;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] cell_q;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;

    nvb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .ld_data(evt.rd_go), .ld_value(cell_q),
        .arm(arm), .busy(busy), .addr_q(addr_q), .data_q(data_q),
        .req(req), .bus_rdata(bus_rdata)
    );

    nvb_seq #(
        .RD_STALL(RD_STALL), .WR_STALL(WR_STALL),
        .ARM_WIN(ARM_WIN), .WR_CYCLES(WR_CYCLES)
    ) u_seq (
        .clk(clk), .rst(rst), .req(req), .evt(evt),
        .stall(cpu_stall), .busy(busy), .arm(arm)
    );

    // Write is captured on acceptance and committed when the timer ends
    always_ff @(posedge clk) begin
        if (evt.wr_go) begin
            pend_addr <= addr_q;
            pend_data <= data_q;
        end
    end

    nvb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .we(evt.wr_done), .waddr(pend_addr), .wdata(pend_data),
        .raddr(addr_q), .rdata(cell_q)
    );

endmodule

// File: rtl/nvb_ctrl_chk.sv
module nvb_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        bus_sel,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cpu_stall,
    input logic              busy,
    input logic              arm
);
    a_r7_no_stall_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cpu_stall);

    a_r2_hi_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_sel == 2'd3 |-> bus_rdata[DATA_W-1:1] == '0);

    a_r11_strobes_read_zero: assert property (@(posedge clk) disable iff (rst)
        bus_sel == 2'd0 |-> bus_rdata[1:0] == 2'b00);

    a_r8_busy_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(arm));

    a_r9_arm_cleared_on_accept: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !arm);

    a_r5_write_stalls: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> cpu_stall);

    a_r10_no_new_stall_when_busy: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> !$rose(cpu_stall));

    a_r4_stall_min_two: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_stall) |=> cpu_stall);

endmodule

bind nvb_ctrl nvb_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rdata(bus_rdata),
    .cpu_stall(cpu_stall), .busy(busy), .arm(arm)
);

// File: tb/nvb_ctrl_bench.sv
module nvb_ctrl_bench;
    localparam int WRC = 40;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_we;
    logic [1:0] bus_sel;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       cpu_stall;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    nvb_ctrl #(.WR_CYCLES(WRC)) u_nvb_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_stall(cpu_stall)
    );

    // ---------------- behavioural reference model ----------------
    int   m_arm, m_stall, m_busy;
    int   m_addr, p_addr;
    logic [7:0] m_data, p_data;
    logic [7:0] m_mem [512];
    bit   lo_known = 0, hi_known = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_arm = 0; m_stall = 0; m_busy = 0; m_data = 8'h00;
        end else begin
            bit c, rr, rw, ra, idle, wgo, rgo, commit;
            c  = bus_we && bus_sel == 2'd0;
            rr = c && bus_wdata[0];
            rw = c && bus_wdata[1];
            ra = c && bus_wdata[2];
            idle   = (m_busy == 0) && (m_stall == 0);
            wgo    = rw && !ra && (m_arm > 0) && idle;
            rgo    = rr && !rw && idle;
            commit = (m_busy == 1);
            if (commit) m_mem[p_addr] = p_data;
            if (m_stall > 0) m_stall--;
            if (m_busy > 0)  m_busy--;
            if (wgo) m_arm = 0;
            else if (ra) m_arm = 4;
            else if (m_arm > 0) m_arm--;
            if (rgo) begin m_data = m_mem[m_addr]; m_stall = 4; end
            if (wgo) begin p_addr = m_addr; p_data = m_data; m_stall = 2; m_busy = WRC; end
            if (bus_we && bus_sel == 2'd1 && !rgo) m_data = bus_wdata;
            if (bus_we && bus_sel == 2'd2) begin m_addr = (m_addr & 256) | int'(bus_wdata); lo_known = 1; end
            if (bus_we && bus_sel == 2'd3) begin m_addr = (m_addr & 255) | (int'(bus_wdata[0]) << 8); hi_known = 1; end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [7:0] e;
            bit known;
            known = 1;
            case (bus_sel)
                2'd0: e = {4'b0, m_busy > 0, m_arm > 0, 2'b00};
                2'd1: e = m_data;
                2'd2: begin e = 8'(m_addr); known = lo_known; end
                default: begin e = {7'b0, 1'(m_addr >> 8)}; known = hi_known; end
            endcase
            if (known) check(bus_rdata == e, "R3", bus_rdata, e);
            check(cpu_stall == (m_stall > 0), "R4", 32'(cpu_stall), 32'(m_stall > 0));
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] v);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_sel = s; bus_wdata = v;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [7:0] v);
        bus_sel = s; #1; v = bus_rdata;
    endtask

    task automatic idle(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic set_addr(input int a);
        bus_wr(2'd2, 8'(a));
        bus_wr(2'd3, 8'(a >> 8));
    endtask

    // run until quiet; returns stall and busy cycle counts
    task automatic drain(output int ns, output int nb);
        logic [7:0] v;
        ns = 0; nb = 0;
        peek(2'd0, v);
        while (cpu_stall || v[3]) begin
            if (cpu_stall) ns++;
            if (v[3]) nb++;
            @(posedge clk); #1;
            peek(2'd0, v);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ (a >> 1));
    endfunction

    logic [7:0] expv [512];

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int ns, nb;
        rst = 1'b1; bus_we = 1'b0; bus_sel = 2'd0; bus_wdata = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R7 reset state
        peek(2'd1, v); check(v == 8'h00, "R7", v, 0);
        peek(2'd0, v); check(v == 8'h00, "R7", v, 0);
        check(cpu_stall == 1'b0, "R7", 32'(cpu_stall), 0);

        // R2 high address byte
        bus_wr(2'd3, 8'hFF); peek(2'd3, v); check(v == 8'h01, "R2", v, 1);
        bus_wr(2'd2, 8'h5A); peek(2'd2, v); check(v == 8'h5A, "R2", v, 8'h5A);

        // R1 R3 R5 R6 fill every location
        for (int a = 0; a < 512; a++) begin
            set_addr(a);
            bus_wr(2'd1, pat(a));
            expv[a] = pat(a);
            bus_wr(2'd0, 8'h04);
            bus_wr(2'd0, 8'h02);
            drain(ns, nb);
            if (a == 0 || a == 511) begin
                check(ns == 2, "R5", ns, 2);
                check(nb == WRC, "R6", nb, WRC);
            end
        end

        // R8 unarmed write strobe
        set_addr(5); bus_wr(2'd1, 8'hEE);
        idle(6);
        bus_wr(2'd0, 8'h02);
        check(cpu_stall == 1'b0, "R8", 32'(cpu_stall), 0);
        peek(2'd0, v); check(v[3] == 1'b0, "R8", v, 0);
        // R8 arm and write in one bus write
        bus_wr(2'd0, 8'h06);
        check(cpu_stall == 1'b0, "R8", 32'(cpu_stall), 0);
        peek(2'd0, v); check(v == 8'h04, "R8", v, 4);
        idle(6);

        // R9 strobe one edge after the window closed
        bus_wr(2'd0, 8'h04);
        idle(3);
        bus_wr(2'd0, 8'h02);
        check(cpu_stall == 1'b0, "R9", 32'(cpu_stall), 0);
        peek(2'd0, v); check(v == 8'h00, "R9", v, 0);

        // R9 strobe on the last edge of the window
        set_addr(7); bus_wr(2'd1, 8'h77);
        bus_wr(2'd0, 8'h04);
        idle(2);
        bus_wr(2'd0, 8'h02);
        check(cpu_stall == 1'b1, "R9", 32'(cpu_stall), 1);
        peek(2'd0, v); check(v == 8'h08, "R9", v, 8);
        check(v[1:0] == 2'b00, "R11", v, 0);
        expv[7] = 8'h77;
        // R10 read strobe while busy: ignored
        idle(3);
        bus_wr(2'd0, 8'h01);
        check(cpu_stall == 1'b0, "R10", 32'(cpu_stall), 0);
        peek(2'd1, v); check(v == 8'h77, "R10", v, 8'h77);
        drain(ns, nb);

        // R1 R3 R4 read everything back
        for (int a = 0; a < 512; a++) begin
            set_addr(a);
            bus_wr(2'd0, 8'h01);
            drain(ns, nb);
            if (a < 2 || a == 511) check(ns == 4, "R4", ns, 4);
            peek(2'd1, v);
            check(v == expv[a], "R1", v, expv[a]);
        end
        peek(2'd0, v); check(v[1:0] == 2'b00, "R11", v, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule